// File: doc/BRIEF.md
# DMA Channel Chaining Trigger Unit

This block lets one DMA channel start another without software. Each chaining group names a source channel, a destination channel and the completion granularity that counts as "done" on the source. The granularity is one of fragment, block, transfer or link-list. When the source channel reports a chosen completion event, the block issues a one-cycle start pulse on the destination channel's start line. Two groups work side by side and do not affect each other. Each group is set through one 32-bit register on a plain read/write bus with a per-bit write mask, so software can program the fields one at a time.

The channels are modelled only as event sources and start sinks. Every channel drives four completion strobes into the block. The block drives one start line per channel back out, together with four per-channel event outputs. Those outputs repeat the completion strobes one cycle later, except for event types that an enabled group masks on its own source channel.

Top module: `dma_chain_trig`

## Requirements
- R1: Group 0's register is at address 0x28 and group 1's at 0x2C. A read returns the stored fields: bit 24 enable, bits 23:20 event mask, bits 19:16 trigger select, bits 13:8 destination, bits 5:0 source. Bits 31:25, 15:14 and 7:6 read as zero. At any other address, reads return zero and writes change nothing.
- R2: A write changes only the bits set in the write mask. All other stored bits keep their values, so the source and destination fields can be programmed by separate accesses.
- R3: Synchronous active-low reset clears both group registers and all start and event outputs to zero.
- R4: Channel fields are one-based: hardware channel k is written as k+1. A group never fires if it is disabled, if its source or destination field is 0 or greater than the channel count (32), or if its trigger select is zero.
- R5: When a group fires, the destination channel's start bit is high for exactly the one cycle after the cycle in which the selected event is seen. An event on any channel other than the group's source causes no start.
- R6: The trigger select is one-hot per event type: bit 16 fragment, bit 17 block, bit 18 transfer, bit 19 link-list. If several bits are set, any one of the selected events fires the group.
- R7: The two groups fire independently in the same cycle. If both target the same destination in the same cycle, the result is a single start bit.
- R8: Mask bit 20+j suppresses event type j (0 fragment, 1 block, 2 transfer, 3 link-list) of an enabled group's valid source channel on the event outputs. The mask never affects triggering, and it has no effect while the group is disabled.
- R9: Every event that no group masks appears on the matching event output one cycle after it appears on the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_wmask_i | input | 32 | Per-bit write enable |
| reg_rdata_o | output | 32 | Read data, combinational from address |
| ev_frag_i | input | 32 | Fragment-done strobe per channel |
| ev_blk_i | input | 32 | Block-done strobe per channel |
| ev_xfer_i | input | 32 | Transfer-done strobe per channel |
| ev_list_i | input | 32 | Link-list-done strobe per channel |
| start_o | output | 32 | One-cycle start pulse per destination channel |
| irq_frag_o | output | 32 | Forwarded fragment events after masking |
| irq_blk_o | output | 32 | Forwarded block events after masking |
| irq_xfer_o | output | 32 | Forwarded transfer events after masking |
| irq_list_o | output | 32 | Forwarded link-list events after masking |

## Verification
The assertions check the following on every cycle:
- A configuration never changes without a write.
- A misconfigured group never fires.
- No start pulse follows a cycle with no events.
- Start pulses never outnumber the groups.
- A forwarded event output never shows a bit that was not on its input the cycle before.

Only the bench's scenarios can show the rest:
- the one-cycle timing and the correct destination bit;
- how each trigger-select pattern maps to event types;
- masked-write merging;
- the mapping between mask bits and event types;
- the merging of collisions between the two groups.

// File: rtl/dct_pkg.sv
// Package: shared types and field layout for the DMA chaining trigger unit.
// Assumes one 32-bit configuration word per chaining group.
package dct_pkg;

    localparam int CH_W  = 6;  // width of a one-based channel field
    localparam int EV_N  = 4;  // event types: 0 frag, 1 block, 2 transfer, 3 list

    typedef struct packed {
        logic              en;
        logic [EV_N-1:0]   imask;
        logic [EV_N-1:0]   trig;
        logic [CH_W-1:0]   dst;
        logic [CH_W-1:0]   src;
    } grp_cfg_t;

    // Pack stored fields into the bus word; reserved bits are zero.
    function automatic logic [31:0] cfg_to_word(input grp_cfg_t c);
        return {7'd0, c.en, c.imask, c.trig, 2'd0, c.dst, 2'd0, c.src};
    endfunction

endpackage

// File: rtl/dct_cfg_regs.sv
// Module: configuration registers, one per chaining group, at
// GRP_BASE + 4*g. Writes merge under a per-bit mask. Reads are
// combinational. Assumes the addresses are byte addresses and the
// bus is single-cycle.
module dct_cfg_regs
    import dct_pkg::*;
#(
    parameter int NUM_GRP  = 2,
    parameter int ADDR_W   = 12,
    parameter int GRP_BASE = 'h28
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [31:0]              wdata_i,
    input  logic [31:0]              wmask_i,
    output logic [31:0]              rdata_o,
    output grp_cfg_t [NUM_GRP-1:0]   cfg_o
);

    grp_cfg_t [NUM_GRP-1:0] cfg_q;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_reg
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(GRP_BASE + 4 * g);
        logic        hit;
        logic [31:0] merged;
        logic        unused_rsvd;

        assign hit    = wr_i && (addr_i == MY_ADDR);
        assign merged = (cfg_to_word(cfg_q[g]) & ~wmask_i) | (wdata_i & wmask_i);
        assign unused_rsvd = ^{merged[31:25], merged[15:14], merged[7:6]};

        // Holds one group's fields; updates only on an addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[g] <= '0;
            end else if (hit) begin
                cfg_q[g] <= grp_cfg_t'({merged[24:16], merged[13:8], merged[5:0]});
            end
        end

        // R2: without a write strobe a group's configuration never moves.
        a_r2_hold_unaddressed: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_i |=> $stable(cfg_q[g]));
    end

    // Read mux: the addressed group's word, or zero for any other address.
    always_comb begin
        rdata_o = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (addr_i == ADDR_W'(GRP_BASE + 4 * g)) begin
                rdata_o = cfg_to_word(cfg_q[g]);
            end
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/dct_group_match.sv
// Module: evaluates one chaining group. It selects the source channel's
// four events, decides whether the group fires, and produces the
// event-suppression map used to mask the forwarded events.
// Assumes NUM_CH is at least 2 and at most 2**CH_W - 1.
module dct_group_match
    import dct_pkg::*;
#(
    parameter int NUM_CH = 32,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  grp_cfg_t                     cfg_i,
    input  logic [EV_N-1:0][NUM_CH-1:0]  ev_i,
    output logic                         fire_o,
    output logic [IDX_W-1:0]             dst_idx_o,
    output logic [EV_N-1:0][NUM_CH-1:0]  supp_o
);

    logic             src_ok, dst_ok;
    logic [IDX_W-1:0] src_idx;
    logic [EV_N-1:0]  src_ev;

    assign src_ok    = (cfg_i.src != '0) && (cfg_i.src <= CH_W'(NUM_CH));
    assign dst_ok    = (cfg_i.dst != '0) && (cfg_i.dst <= CH_W'(NUM_CH));
    assign src_idx   = IDX_W'(cfg_i.src - CH_W'(1));
    assign dst_idx_o = IDX_W'(cfg_i.dst - CH_W'(1));

    // Gathers the four completion strobes of the source channel.
    always_comb begin
        for (int t = 0; t < EV_N; t++) begin
            src_ev[t] = ev_i[t][src_idx];
        end
    end

    // Fire decision: enabled, both channels valid, any selected event present.
    assign fire_o = cfg_i.en && src_ok && dst_ok && |(src_ev & cfg_i.trig);

    // Suppression map: masked event types of a valid source while enabled.
    always_comb begin
        supp_o = '0;
        if (cfg_i.en && src_ok) begin
            for (int t = 0; t < EV_N; t++) begin
                supp_o[t][src_idx] = cfg_i.imask[t];
            end
        end
    end

    // R4: a misconfigured or disabled group is silent.
    a_r4_unassigned_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_i.en || cfg_i.trig == '0 || cfg_i.src == '0 || cfg_i.dst == '0) |-> !fire_o);

    // R8: one group masks at most one channel per event type.
    a_r8_supp_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(supp_o) <= EV_N);

endmodule

// File: rtl/dma_chain_trig.sv
// Module: top of the DMA channel chaining trigger unit. It instantiates
// the register file and one matcher per group, merges the start requests
// and forwarded events, and registers both one cycle.
// Assumes event inputs are synchronous to clk.
module dma_chain_trig
    import dct_pkg::*;
#(
    parameter int NUM_CH   = 32,
    parameter int NUM_GRP  = 2,
    parameter int ADDR_W   = 12,
    parameter int GRP_BASE = 'h28,
    localparam int IDX_W   = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    input  logic [31:0]       reg_wmask_i,
    output logic [31:0]       reg_rdata_o,
    input  logic [NUM_CH-1:0] ev_frag_i,
    input  logic [NUM_CH-1:0] ev_blk_i,
    input  logic [NUM_CH-1:0] ev_xfer_i,
    input  logic [NUM_CH-1:0] ev_list_i,
    output logic [NUM_CH-1:0] start_o,
    output logic [NUM_CH-1:0] irq_frag_o,
    output logic [NUM_CH-1:0] irq_blk_o,
    output logic [NUM_CH-1:0] irq_xfer_o,
    output logic [NUM_CH-1:0] irq_list_o
);

    grp_cfg_t [NUM_GRP-1:0]              cfg;
    logic [EV_N-1:0][NUM_CH-1:0]         ev_all;
    logic [NUM_GRP-1:0]                  fire;
    logic [NUM_GRP-1:0][IDX_W-1:0]       dst_idx;
    logic [NUM_GRP-1:0][EV_N-1:0][NUM_CH-1:0] supp;
    logic [EV_N-1:0][NUM_CH-1:0]         supp_any, irq_d, irq_q;
    logic [NUM_CH-1:0]                   start_d, start_q;

    assign ev_all = {ev_list_i, ev_xfer_i, ev_blk_i, ev_frag_i};

    dct_cfg_regs #(
        .NUM_GRP (NUM_GRP),
        .ADDR_W  (ADDR_W),
        .GRP_BASE(GRP_BASE)
    ) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (reg_wr_i),
        .addr_i (reg_addr_i),
        .wdata_i(reg_wdata_i),
        .wmask_i(reg_wmask_i),
        .rdata_o(reg_rdata_o),
        .cfg_o  (cfg)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        dct_group_match #(.NUM_CH(NUM_CH)) match_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_i    (cfg[g]),
            .ev_i     (ev_all),
            .fire_o   (fire[g]),
            .dst_idx_o(dst_idx[g]),
            .supp_o   (supp[g])
        );
    end

    // Start merge: OR every firing group's destination bit.
    always_comb begin
        start_d = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (fire[g]) start_d[dst_idx[g]] = 1'b1;
        end
    end

    // Event forwarding: clear every bit some enabled group masks.
    always_comb begin
        supp_any = '0;
        for (int g = 0; g < NUM_GRP; g++) supp_any = supp_any | supp[g];
        irq_d = ev_all & ~supp_any;
    end

    // Output stage: one register on start pulses and forwarded events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            irq_q   <= '0;
        end else begin
            start_q <= start_d;
            irq_q   <= irq_d;
        end
    end

    assign start_o    = start_q;
    assign irq_frag_o = irq_q[0];
    assign irq_blk_o  = irq_q[1];
    assign irq_xfer_o = irq_q[2];
    assign irq_list_o = irq_q[3];

    // R5: no start pulse follows a cycle with no completion events.
    a_r5_no_event_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_all == '0) |=> (start_o == '0));

    // R7: simultaneous starts never exceed the number of groups.
    a_r7_start_bound: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(start_o) <= NUM_GRP);

    // R9: a forwarded event always had its input strobe one cycle earlier.
    a_r9_irq_from_input: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irq_q & ~$past(ev_all)) == '0));

endmodule

// File: tb/dma_chain_trig_tb_top.sv
// Bench: sweeps trigger-select patterns, event types, mask patterns and
// channel-field corner cases. Expected values come from the requirements.
module dma_chain_trig_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 32;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            reg_wr;
    logic [11:0]     reg_addr;
    logic [31:0]     reg_wdata, reg_wmask, reg_rdata;
    logic [NCH-1:0]  ev_f, ev_b, ev_x, ev_l;
    logic [NCH-1:0]  start, irq_f, irq_b, irq_x, irq_l;

    int n_vec = 0;
    int n_err = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_chain_trig dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr_i   (reg_wr),
        .reg_addr_i (reg_addr),
        .reg_wdata_i(reg_wdata),
        .reg_wmask_i(reg_wmask),
        .reg_rdata_o(reg_rdata),
        .ev_frag_i  (ev_f),
        .ev_blk_i   (ev_b),
        .ev_xfer_i  (ev_x),
        .ev_list_i  (ev_l),
        .start_o    (start),
        .irq_frag_o (irq_f),
        .irq_blk_o  (irq_b),
        .irq_xfer_o (irq_x),
        .irq_list_o (irq_l)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [31:0] m);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_wmask = m;
        @(negedge clk);
        reg_wr = 1'b0; reg_wmask = '0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Drive one cycle of events, then sample the registered outputs.
    task automatic pulse(input logic [NCH-1:0] f, input logic [NCH-1:0] b,
                         input logic [NCH-1:0] x, input logic [NCH-1:0] l);
        ev_f = f; ev_b = b; ev_x = x; ev_l = l;
        @(negedge clk);
        ev_f = '0; ev_b = '0; ev_x = '0; ev_l = '0;
    endtask

    function automatic logic [31:0] cfgw(input int en, input int mask, input int trig,
                                         input int dst, input int src);
        return (32'(en) << 24) | (32'(mask) << 20) | (32'(trig) << 16) |
               (32'(dst) << 8) | 32'(src);
    endfunction

    // Event vector for type t on channel ch: returns 4 vectors packed.
    function automatic logic [3:0][NCH-1:0] one_ev(input int t, input int ch);
        logic [3:0][NCH-1:0] v = '0;
        v[t][ch] = 1'b1;
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [3:0][NCH-1:0] e;
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; reg_wmask = '0;
        ev_f = '0; ev_b = '0; ev_x = '0; ev_l = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3: reset state.
        rd(12'h28, r); chk("R3 grp0 reset", r, 0);
        rd(12'h2C, r); chk("R3 grp1 reset", r, 0);
        chk("R3 start reset", start, 0);
        chk("R3 irq reset", irq_f | irq_b | irq_x | irq_l, 0);

        // R1: read-back with reserved bits zero, other addresses inert.
        wr(12'h28, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        rd(12'h28, r); chk("R1 grp0 readback", r, 32'h01FF_3F3F);
        rd(12'h2C, r); chk("R1 grp1 untouched", r, 0);
        wr(12'h30, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        rd(12'h30, r); chk("R1 other addr reads zero", r, 0);
        rd(12'h2C, r); chk("R1 other addr write ignored", r, 0);
        wr(12'h28, 0, 32'hFFFF_FFFF);
        rd(12'h28, r); chk("R1 grp0 cleared", r, 0);

        // R2: field-by-field programming under the write mask.
        wr(12'h2C, cfgw(1, 0, 0, 0, 5), cfgw(1, 0, 0, 0, 5));
        wr(12'h2C, cfgw(1, 0, 0, 10, 0), cfgw(1, 0, 0, 10, 0));
        rd(12'h2C, r); chk("R2 src then dst", r, cfgw(1, 0, 0, 10, 5));
        wr(12'h2C, 32'hFFFF_FFFF, 32'h000F_0000);
        rd(12'h2C, r); chk("R2 trig only", r, cfgw(1, 0, 15, 10, 5));
        wr(12'h2C, 32'h0000_0000, 32'h0000_003F);
        rd(12'h2C, r); chk("R2 src cleared only", r, cfgw(1, 0, 15, 10, 0));
        wr(12'h2C, 0, 32'hFFFF_FFFF);

        // R5/R6: sweep trigger-select patterns and event types on each group.
        for (int g = 0; g < 2; g++) begin
            for (int tr = 0; tr < 16; tr++) begin
                int src = g * 7 + 3 + tr;
                int dst = 32 - tr - g;
                wr(12'(12'h28 + 4 * g), cfgw(1, 0, tr, dst, src), 32'hFFFF_FFFF);
                for (int t = 0; t < 4; t++) begin
                    logic [NCH-1:0] exp_s;
                    exp_s = tr[t] ? (32'd1 << (dst - 1)) : 32'd0;
                    e = one_ev(t, src - 1);
                    pulse(e[0], e[1], e[2], e[3]);
                    chk("R6 trigger select", start, exp_s);
                    chk("R9 forwarded event", (t == 0) ? irq_f : (t == 1) ? irq_b :
                        (t == 2) ? irq_x : irq_l, 32'd1 << (src - 1));
                    @(negedge clk);
                    chk("R5 single cycle pulse", start, 0);
                    e = one_ev(t, src % NCH);
                    pulse(e[0], e[1], e[2], e[3]);
                    chk("R5 other channel no start", start, 0);
                end
            end
            wr(12'(12'h28 + 4 * g), 0, 32'hFFFF_FFFF);
        end

        // R8: mask sweep; masks never block the start.
        for (int m = 0; m < 16; m++) begin
            wr(12'h28, cfgw(1, m, 15, 3, 7), 32'hFFFF_FFFF);
            for (int t = 0; t < 4; t++) begin
                logic [NCH-1:0] exp_i;
                e = one_ev(t, 6);
                e[t][20] = 1'b1;
                pulse(e[0], e[1], e[2], e[3]);
                exp_i = (m[t] ? 32'd0 : (32'd1 << 6)) | (32'd1 << 20);
                chk("R8 mask on forward", (t == 0) ? irq_f : (t == 1) ? irq_b :
                    (t == 2) ? irq_x : irq_l, exp_i);
                chk("R8 mask keeps trigger", start, 32'd1 << 2);
            end
        end
        wr(12'h28, cfgw(0, 15, 15, 3, 7), 32'hFFFF_FFFF);
        pulse('1, '1, '1, '1);
        chk("R8 mask inert when disabled", irq_f & irq_b & irq_x & irq_l, 32'hFFFF_FFFF);
        chk("R4 disabled no start", start, 0);

        // R4: unassigned or out-of-range channel fields never fire.
        wr(12'h28, cfgw(1, 0, 15, 3, 0), 32'hFFFF_FFFF);
        pulse('1, '1, '1, '1);
        chk("R4 src zero", start, 0);
        wr(12'h28, cfgw(1, 0, 15, 0, 7), 32'hFFFF_FFFF);
        pulse('1, '1, '1, '1);
        chk("R4 dst zero", start, 0);
        wr(12'h28, cfgw(1, 0, 15, 3, 33), 32'hFFFF_FFFF);
        pulse('1, '1, '1, '1);
        chk("R4 src out of range", start, 0);
        wr(12'h28, cfgw(1, 0, 15, 40, 7), 32'hFFFF_FFFF);
        pulse('1, '1, '1, '1);
        chk("R4 dst out of range", start, 0);
        wr(12'h28, cfgw(1, 0, 0, 3, 7), 32'hFFFF_FFFF);
        pulse('1, '1, '1, '1);
        chk("R4 no trigger bit", start, 0);

        // R7: two groups together; shared destination merges.
        wr(12'h28, cfgw(1, 0, 1, 9, 1), 32'hFFFF_FFFF);
        wr(12'h2C, cfgw(1, 0, 8, 9, 2), 32'hFFFF_FFFF);
        pulse(32'h1, 0, 0, 32'h2);
        chk("R7 shared destination", start, 32'h0000_0100);
        wr(12'h2C, cfgw(1, 0, 8, 12, 2), 32'hFFFF_FFFF);
        pulse(32'h1, 0, 0, 32'h2);
        chk("R7 two destinations", start, 32'h0000_0900);
        wr(12'h2C, cfgw(1, 0, 1, 32, 1), 32'hFFFF_FFFF);
        pulse(32'h1, 0, 0, 0);
        chk("R7 shared source", start, 32'h8000_0100);

        // R3: reset mid-operation clears the configuration.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(12'h2C, r); chk("R3 re-reset clears", r, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule